// File: doc/BRIEF.md
# Indirect Video Memory Access Port

This block lets a 16-bit processor bus reach a video memory that is not mapped into the processor's address space. Software programs an address pointer, then moves words through a data register; a signed step value advances the pointer after each data store, so a run of stores walks through memory with any stride, forwards or backwards.

Reads never touch memory directly. A one-word read buffer is refilled by a prefetch after every pointer write and after every data store, and any read of the pointer or data register returns that buffer without moving the pointer. This makes a read-modify-write on the data register land on the same word it just read. The upper half of the 64K-word space is served by a small attribute array that repeats across that half; the lower half by a main array. The pointer step keeps the top pointer bit, so each half wraps on itself.

Top module: `vram_port`

## Requirements
- R1: After reset the pointer, the step register and the read buffer are all 0x0000 and `busy` is low.
- R2: A word write to byte address 0 loads the pointer; `busy` is high for the two cycles after the write edge and low on the third, when the read buffer holds the memory word at the new pointer.
- R3: A word write to byte address 2 stores the data at the current pointer, then sets the pointer to {old bit 15, low 15 bits of (pointer + step)} and prefetches from that new pointer with the same `busy` timing as R2.
- R4: Word reads at byte address 0 or 2 return the read buffer and change neither the pointer nor the buffer.
- R5: A write to byte address 4 stores all 16 bits in the step register and a word read there returns them; only step bits 14:0 enter the addition, so 0x7FFE, 0x7FFF, 0x0000, 0x0001, 0x0002 step by -2, -1, 0, +1, +2 and 0x8001 steps by +1.
- R6: Pointer bit 15 = 0 selects the main array, indexed by the low MAIN_AW bits; bit 15 = 1 selects the attribute array, indexed by the low ATTR_AW bits, so it repeats every 2**ATTR_AW words across the upper half.
- R7: A byte write (`bus_byte`=1) at an even address writes {wdata[7:0], wdata[7:0]} as a word write would; a byte write at an odd address has no effect at all.
- R8: A byte read at an even address returns {8'h00, high byte of the register word}; a byte read at an odd address returns 0x0000.
- R9: While `busy` is high, pointer and data writes are dropped, reads return the old buffer, and step writes are accepted.
- R10: Byte address 6 reads as 0x0000 and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte address within the register window |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| bus_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| bus_rdata | output | 16 | Read data for the addressed register, combinational |
| busy | output | 1 | Prefetch in progress |

## Verification
The two functions that meet in one cycle are a pending prefetch and a new bus access: while the buffer refill is still in flight, the bench issues a pointer write, a buffer read and a step write in the busy cycles. The dropped pointer write is judged by the buffer and later store locations matching the model that never took it, the read by returning the pre-refill buffer, and the step write by its read-back and the stride of the following store. Constrained random traffic with a fixed seed then mixes all access kinds against a model memory.

// File: rtl/vram_port_pkg.sv
package vram_port_pkg;

    typedef enum logic [1:0] {
        REG_OFFSET = 2'd0,
        REG_DATA   = 2'd1,
        REG_STEP   = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        PF_IDLE  = 2'd0,
        PF_FETCH = 2'd1,
        PF_LOAD  = 2'd2
    } pf_state_e;

    typedef struct packed {
        logic        valid;
        logic        write;
        reg_sel_e    sel;
        logic [15:0] data;
    } bus_op_t;

    // Pointer advance: top bit kept, low 15 bits wrap.
    function automatic logic [15:0] advance(input logic [15:0] ptr, input logic [15:0] step);
        logic [14:0] low;
        low = ptr[14:0] + step[14:0];
        return {ptr[15], low};
    endfunction

    function automatic logic [15:0] lane_view(input logic [15:0] word, input logic is_byte,
                                              input logic odd);
        if (!is_byte) return word;
        if (odd)      return 16'h0000;
        return {8'h00, word[15:8]};
    endfunction

endpackage

// File: rtl/vram_port_lane.sv
module vram_port_lane
    import vram_port_pkg::*;
(
    input  logic        req,
    input  logic        we,
    input  logic [2:0]  addr,
    input  logic        is_byte,
    input  logic [15:0] wdata,
    output bus_op_t     op
);
    always_comb begin
        op.sel   = reg_sel_e'(addr[2:1]);
        op.write = we;
        op.valid = req && !(we && is_byte && addr[0]);
        op.data  = is_byte ? {2{wdata[7:0]}} : wdata;
    end
endmodule

// File: rtl/vram_port_store.sv
module vram_port_store #(
    parameter int MAIN_AW = 10,
    parameter int ATTR_AW = 9
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] wr_addr,
    input  logic [15:0] wr_data,
    input  logic        rd_en,
    input  logic [15:0] rd_addr,
    output logic [15:0] rd_q
);
    logic bank_q;
    logic unused_bits;
    assign unused_bits = ^{wr_addr[14:0], rd_addr[14:0]};

    for (genvar g = 0; g < 2; g++) begin : g_bank
        localparam int  AW       = (g == 0) ? MAIN_AW : ATTR_AW;
        localparam int  DEPTH    = 1 << AW;
        localparam logic BANK_ID = 1'(g);
        logic [15:0] mem [DEPTH];
        logic [15:0] q;
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr[15] == BANK_ID))
                mem[wr_addr[AW-1:0]] <= wr_data;
            if (rd_en && (rd_addr[15] == BANK_ID))
                q <= mem[rd_addr[AW-1:0]];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        bank_q <= 1'b0;
        else if (rd_en) bank_q <= rd_addr[15];
    end

    assign rd_q = bank_q ? g_bank[1].q : g_bank[0].q;
endmodule

// File: rtl/vram_port_ctrl.sv
module vram_port_ctrl
    import vram_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  bus_op_t     op,
    input  logic        is_byte,
    input  logic        odd,
    output logic [15:0] rdata,
    output logic        busy,
    output logic        mem_wr_en,
    output logic [15:0] mem_wr_addr,
    output logic [15:0] mem_wr_data,
    output logic        mem_rd_en,
    output logic [15:0] mem_rd_addr,
    input  logic [15:0] mem_q
);
    pf_state_e   state;
    logic [15:0] ptr;
    logic [15:0] step;
    logic [15:0] rbuf;
    logic [15:0] word;
    logic        take_step, take_ptr, take_data;

    always_comb begin
        take_step = op.valid && op.write && (op.sel == REG_STEP);
        take_ptr  = op.valid && op.write && (op.sel == REG_OFFSET) && (state == PF_IDLE);
        take_data = op.valid && op.write && (op.sel == REG_DATA)   && (state == PF_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PF_IDLE;
            ptr   <= '0;
            step  <= '0;
            rbuf  <= '0;
        end else begin
            if (take_step) step <= op.data;
            if (take_ptr)  ptr  <= op.data;
            if (take_data) ptr  <= advance(ptr, step);
            unique case (state)
                PF_IDLE:  if (take_ptr || take_data) state <= PF_FETCH;
                PF_FETCH: state <= PF_LOAD;
                PF_LOAD: begin
                    rbuf  <= mem_q;
                    state <= PF_IDLE;
                end
                default:  state <= PF_IDLE;
            endcase
        end
    end

    assign busy        = (state != PF_IDLE);
    assign mem_wr_en   = take_data;
    assign mem_wr_addr = ptr;
    assign mem_wr_data = op.data;
    assign mem_rd_en   = (state == PF_FETCH);
    assign mem_rd_addr = ptr;

    always_comb begin
        unique case (op.sel)
            REG_OFFSET, REG_DATA: word = rbuf;
            REG_STEP:             word = step;
            default:              word = 16'h0000;
        endcase
        rdata = lane_view(word, is_byte, odd);
    end

    AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (take_ptr || take_data) |=> busy) else $error("busy not raised"); // R2
    AST_BUSY_TWO_MAX: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |=> !busy) else $error("busy too long"); // R2
    AST_BUF_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        (state != PF_LOAD) |=> $stable(rbuf)) else $error("buffer moved"); // R4
    AST_READ_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
        (op.valid && !op.write && !take_step) |=> $stable(ptr)) else $error("read moved ptr"); // R4
    AST_TOP_BIT_KEPT: assert property (@(posedge clk) disable iff (rst)
        take_data |=> (ptr[15] == $past(ptr[15]))) else $error("half changed"); // R3
    AST_DROP_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && op.valid && op.write && (op.sel != REG_STEP)) |=> $stable(ptr))
        else $error("write taken while busy"); // R9
endmodule

// File: rtl/vram_port.sv
module vram_port
    import vram_port_pkg::*;
#(
    parameter int MAIN_AW = 10,
    parameter int ATTR_AW = 9
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic        bus_byte,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        busy
);
    bus_op_t     op;
    logic        wr_en, rd_en;
    logic [15:0] wr_addr, wr_data, rd_addr, mem_q;

    vram_port_lane u_lane (
        .req(bus_req), .we(bus_we), .addr(bus_addr), .is_byte(bus_byte),
        .wdata(bus_wdata), .op(op)
    );

    vram_port_ctrl u_ctrl (
        .clk(clk), .rst(rst), .op(op), .is_byte(bus_byte), .odd(bus_addr[0]),
        .rdata(bus_rdata), .busy(busy),
        .mem_wr_en(wr_en), .mem_wr_addr(wr_addr), .mem_wr_data(wr_data),
        .mem_rd_en(rd_en), .mem_rd_addr(rd_addr), .mem_q(mem_q)
    );

    vram_port_store #(.MAIN_AW(MAIN_AW), .ATTR_AW(ATTR_AW)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_q(mem_q)
    );

    AST_ODD_BYTE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_byte && bus_addr[0] && !busy) |=> !busy)
        else $error("odd byte write started prefetch"); // R7
endmodule

// File: tb/vram_port_tb.sv
module vram_port_tb;
    localparam int MAIN_AW = 10;
    localparam int ATTR_AW = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, we = 1'b0, byte_acc = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        busy;
    int          n_chk = 0, n_fail = 0;

    logic [15:0] m_main [1 << MAIN_AW];
    logic [15:0] m_attr [1 << ATTR_AW];
    logic [15:0] m_ptr = 0, m_step = 0, m_buf = 0;
    bit          chk_buf = 1'b1;

    always #4 clk = ~clk;

    vram_port #(.MAIN_AW(MAIN_AW), .ATTR_AW(ATTR_AW)) u_dut (
        .clk(clk), .rst(rst), .bus_req(req), .bus_we(we), .bus_addr(addr),
        .bus_byte(byte_acc), .bus_wdata(wdata), .bus_rdata(rdata), .busy(busy)
    );

    function automatic logic [15:0] m_rd(input logic [15:0] p);
        return p[15] ? m_attr[p[ATTR_AW-1:0]] : m_main[p[MAIN_AW-1:0]];
    endfunction

    function automatic logic [15:0] m_next(input logic [15:0] p, input logic [15:0] s);
        logic [14:0] lo;
        lo = p[14:0] + s[14:0];
        return {p[15], lo};
    endfunction

    function automatic logic [15:0] exp_read(input logic [2:0] a, input logic b);
        logic [15:0] w;
        w = (a[2:1] == 2'd0 || a[2:1] == 2'd1) ? m_buf : (a[2:1] == 2'd2) ? m_step : 16'h0000;
        if (!b) return w;
        return a[0] ? 16'h0000 : {8'h00, w[15:8]};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_write(input logic [2:0] a, input logic b, input logic [15:0] d,
                               output bit pf);
        logic [15:0] v;
        pf = 1'b0;
        if (b && a[0]) return;
        v = b ? {d[7:0], d[7:0]} : d;
        case (a[2:1])
            2'd0: begin m_ptr = v; pf = 1'b1; end
            2'd1: begin
                if (m_ptr[15]) m_attr[m_ptr[ATTR_AW-1:0]] = v;
                else           m_main[m_ptr[MAIN_AW-1:0]] = v;
                m_ptr = m_next(m_ptr, m_step);
                pf = 1'b1;
            end
            2'd2: m_step = v;
            default: ;
        endcase
        if (pf) m_buf = m_rd(m_ptr);
    endtask

    task automatic put(input logic w, input logic [2:0] a, input logic b, input logic [15:0] d);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; byte_acc = b; wdata = d;
    endtask

    task automatic release_bus();
        req = 1'b0; we = 1'b0;
    endtask

    task automatic do_read(input logic [2:0] a, input logic b, input string tag);
        put(1'b0, a, b, 16'h0000);
        #1 chk(tag, rdata, exp_read(a, b));
        @(negedge clk);
        release_bus();
    endtask

    task automatic do_write(input logic [2:0] a, input logic b, input logic [15:0] d,
                            input string tag);
        bit pf;
        model_write(a, b, d, pf);
        put(1'b1, a, b, d);
        @(negedge clk);
        release_bus();
        chk({tag, " busy 1st"}, {15'd0, busy}, {15'd0, pf});
        if (pf) begin
            @(negedge clk);
            chk({tag, " busy 2nd"}, {15'd0, busy}, 16'd1);
            @(negedge clk);
            chk({tag, " busy end"}, {15'd0, busy}, 16'd0);
            if (chk_buf) do_read(3'd0, 1'b0, {tag, " buffer"});
        end
    endtask

    initial begin
        logic [15:0] old_buf;
        bit          pf;
        logic [15:0] steps [5];
        steps = '{16'h7FFE, 16'h7FFF, 16'h0000, 16'h0001, 16'h0002};
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < (1 << MAIN_AW); i++) m_main[i] = '0;
        for (int i = 0; i < (1 << ATTR_AW); i++) m_attr[i] = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", {15'd0, busy}, 16'd0);
        do_read(3'd0, 1'b0, "R1 buffer after reset");
        do_read(3'd4, 1'b0, "R1 step after reset");

        // fill both arrays with distinct words, buffer not compared while filling
        chk_buf = 1'b0;
        do_write(3'd4, 1'b0, 16'h0001, "R5 fill step");
        do_write(3'd0, 1'b0, 16'h0000, "R2 fill ptr");
        for (int i = 0; i < (1 << MAIN_AW); i++)
            do_write(3'd2, 1'b0, 16'(i * 37 + 16'h0A00), "R3 fill main");
        do_write(3'd0, 1'b0, 16'h8000, "R2 fill ptr attr");
        for (int i = 0; i < (1 << ATTR_AW); i++)
            do_write(3'd2, 1'b0, 16'(16'hC000 + i * 5), "R6 fill attr");
        chk_buf = 1'b1;

        // pointer load and wrap in both halves
        do_write(3'd0, 1'b0, 16'h0123, "R2 ptr load");
        do_write(3'd0, 1'b0, 16'h7FFF, "R2 ptr top of low half");
        do_write(3'd2, 1'b0, 16'hBEEF, "R3 wrap 7FFF->0000");
        do_write(3'd0, 1'b0, 16'hFFFF, "R2 ptr top of high half");
        do_write(3'd2, 1'b0, 16'h1357, "R3 wrap FFFF->8000");
        do_write(3'd4, 1'b0, 16'h7FFF, "R5 step -1");
        do_write(3'd0, 1'b0, 16'h0000, "R2 ptr 0");
        do_write(3'd2, 1'b0, 16'h2468, "R3 wrap 0000->7FFF");
        do_write(3'd0, 1'b0, 16'h8000, "R2 ptr 8000");
        do_write(3'd2, 1'b0, 16'h369C, "R3 wrap 8000->FFFF");
        do_write(3'd0, 1'b0, 16'h7FFF, "R6 main mirror read-back");

        // each step value
        foreach (steps[k]) begin
            do_write(3'd4, 1'b0, steps[k], "R5 step value");
            do_read(3'd4, 1'b0, "R5 step read-back");
            do_write(3'd0, 1'b0, 16'h0100, "R2 ptr 0100");
            for (int j = 0; j < 3; j++)
                do_write(3'd2, 1'b0, 16'(16'h4000 + k * 16 + j), "R3 step walk");
        end
        do_write(3'd4, 1'b0, 16'h8001, "R5 step bit15 set");
        do_read(3'd4, 1'b0, "R5 full 16-bit read-back");
        do_write(3'd2, 1'b0, 16'h7777, "R5 step 8001 acts as +1");

        // attribute mirror
        do_write(3'd0, 1'b0, 16'hA003, "R6 ptr A003");
        do_write(3'd2, 1'b0, 16'hD00D, "R6 store through mirror");
        do_write(3'd0, 1'b0, 16'h8003, "R6 same word at 8003");
        do_write(3'd0, 1'b0, 16'h8403, "R6 same word at 8403");
        do_read(3'd2, 1'b0, "R4 data read returns buffer");
        do_read(3'd2, 1'b0, "R4 repeated read unchanged");
        do_write(3'd2, 1'b0, 16'h0BAD, "R4 store after reads lands at same ptr");
        do_write(3'd0, 1'b0, 16'h8403, "R4 read-back of that store");

        // byte lanes
        do_write(3'd0, 1'b1, 16'hFF12, "R7 even byte to ptr");
        do_write(3'd4, 1'b1, 16'h0034, "R7 even byte to step");
        do_read(3'd4, 1'b0, "R7 step replicated byte");
        do_write(3'd1, 1'b1, 16'h0055, "R7 odd byte ptr ignored");
        do_write(3'd3, 1'b1, 16'h0066, "R7 odd byte data ignored");
        do_write(3'd5, 1'b1, 16'h0077, "R7 odd byte step ignored");
        do_read(3'd4, 1'b0, "R7 step unchanged");
        do_read(3'd0, 1'b0, "R7 buffer unchanged");
        do_read(3'd4, 1'b1, "R8 even byte read step");
        do_read(3'd5, 1'b1, "R8 odd byte read zero");
        do_read(3'd2, 1'b1, "R8 even byte read buffer");
        do_read(3'd6, 1'b0, "R10 spare reads zero");
        do_write(3'd6, 1'b0, 16'hFFFF, "R10 spare write no prefetch");
        do_read(3'd4, 1'b0, "R10 step unchanged");

        // accesses during the prefetch
        do_write(3'd4, 1'b0, 16'h0001, "R9 step +1");
        do_write(3'd0, 1'b0, 16'h0010, "R9 ptr 0010");
        old_buf = m_buf;
        model_write(3'd2, 1'b0, 16'h5A5A, pf);
        put(1'b1, 3'd2, 1'b0, 16'h5A5A);
        put(1'b1, 3'd0, 1'b0, 16'h0200);
        put(1'b0, 3'd2, 1'b0, 16'h0000);
        #1 chk("R9 read during busy gives old buffer", rdata, old_buf);
        @(negedge clk);
        release_bus();
        chk("R9 busy ends", {15'd0, busy}, 16'd0);
        do_read(3'd0, 1'b0, "R9 ptr write while busy dropped");
        do_write(3'd2, 1'b0, 16'hA5A5, "R9 next store at model ptr");
        model_write(3'd2, 1'b0, 16'h6B6B, pf);
        put(1'b1, 3'd2, 1'b0, 16'h6B6B);
        model_write(3'd4, 1'b0, 16'h0002, pf);
        put(1'b1, 3'd4, 1'b0, 16'h0002);
        @(negedge clk);
        release_bus();
        @(negedge clk);
        do_read(3'd4, 1'b0, "R9 step write taken while busy");
        do_write(3'd2, 1'b0, 16'h7C7C, "R9 store uses new step");
        do_write(3'd2, 1'b0, 16'h7D7D, "R9 second store");

        // constrained random traffic
        for (int n = 0; n < 600; n++) begin
            int unsigned r;
            logic [2:0]  a;
            r = $urandom % 12;
            a = 3'($urandom);
            case (r)
                0, 1:    do_write(3'd0, 1'b0, 16'($urandom), "R2 random ptr");
                2, 3, 4: do_write(3'd2, 1'b0, 16'($urandom), "R3 random store");
                5:       do_write(3'd4, 1'b0, steps[$urandom % 5], "R5 random step");
                6:       do_write(3'd4, 1'b0, 16'($urandom), "R5 random wide step");
                7:       do_write(a, 1'b1, 16'($urandom), "R7 random byte write");
                8, 9:    do_read(a, 1'b0, "R4 random word read");
                10:      do_read(a, 1'b1, "R8 random byte read");
                default: do_write(3'd6, 1'b0, 16'($urandom), "R10 random spare write");
            endcase
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule